// File: doc/BRIEF.md
# Indexed Block-Access SMBus Target

This block is a target on a two-wire SMBus/I2C bus that gives a host access to a small file of byte registers. Each transfer names a starting register and then moves a run of bytes through consecutive registers. The block samples the bus lines with its own system clock and cleans each line before use. It finds start, repeated-start and stop conditions and answers only to a 7-bit address whose low bits come from strap pins. It pulls SDA low through an output-enable and never drives it high.

A write carries the target address with the write bit, a starting index, a byte count and then the data bytes. The count is kept in a dedicated count register. A read first sets the index in a short write phase. It then issues a repeated start with the read bit. The target answers with the stored count byte, followed by register contents from the index onward, for as long as the host acknowledges.

Top module: `smb_idx_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal {BASE_ADDR[6:2], addr_sel}. On any other address it leaves SDA released for the acknowledge bit and ignores every following byte, including a matching address, until the next start condition.
- R2: After a matched write address, the next byte is acknowledged and becomes the register index.
- R3: The byte after the index is acknowledged and stored in the count register, which resets to NREG (8). A read returns this value.
- R4: Data bytes of a write are stored at the current index, and the index steps by one after each byte. All NREG registers reset to zero.
- R5: Once as many data bytes as the count have been taken, a further data byte is not acknowledged and changes no register. With a count of zero, the first data byte is not acknowledged.
- R6: A data byte within the count whose index is NREG or above is acknowledged and discarded.
- R7: A repeated start followed by the read address (bit 0 = 1) is acknowledged. The target then sends, MSB first, the count register and then the registers from the index upward.
- R8: A read at an index of NREG or above returns 8'hFF. A host NACK ends the read, and SDA is left released.
- R9: A stop condition, or a start condition after one or more bits of a byte, aborts the transfer. SDA is released and no partial byte is stored. After such a start the target ignores the bus until a new start.
- R10: The target enables its SDA pull-down only while SCL is low, and SDA is released out of reset.
- R11: Each line passes through a two-flop synchronizer and a filter. A level lasting fewer than FILT (4) system cycles has no effect on either line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | SEL_W | Low bits of the target address |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume a host that follows the bus rules. SDA changes only while SCL is low, except for the start and stop edges, and every SCL phase lasts far longer than the synchronizer and filter delay. Under those conditions a change on SCL seen inside the block always comes before any data change that follows it. The bench host keeps every phase at sixteen system cycles, so it stays within these assumptions. It breaks the rules only in its deliberate glitch pulses, and those are shorter than the filter window.

// File: rtl/smb_idx_pkg.sv
package smb_idx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // ignoring bus until a start
    ST_ADDR,   // shifting in address byte
    ST_IDX,    // shifting in index byte
    ST_CNT,    // shifting in count byte
    ST_WDAT,   // shifting in write data
    ST_ACK,    // target acknowledge bit
    ST_TX,     // target driving a byte
    ST_TACK    // host acknowledge bit
  } smb_st_e;
endpackage

// File: rtl/smb_rst_sync.sv
module smb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int FILT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT + 1);

  logic [1:0]    sync_q;
  logic          out_q, out_d;
  logic [CW-1:0] run_q, run_d;

  always_comb begin
    out_d = out_q;
    run_d = '0;
    if (sync_q[1] != out_q) begin
      if (run_q == CW'(FILT - 1)) out_d = sync_q[1];
      else                        run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      out_q  <= 1'b1;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      out_q  <= out_d;
      run_q  <= run_d;
    end
  end

  assign line_o = out_q;
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl;
      sda_p <= sda;
    end
  end

  assign scl_rise = scl & ~scl_p;
  assign scl_fall = ~scl & scl_p;
  assign start_ev = scl & scl_p & sda_p & ~sda;
  assign stop_ev  = scl & scl_p & ~sda_p & sda;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int NREG = 8,
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] idx,
  input  logic [7:0]      wr_data,
  output logic [7:0]      rd_data
);
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [7:0] mem_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= 8'h00;
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++)
        if (idx == IDXW'(i)) mem_q[i] <= wr_data;
    end
  end

  assign rd_data = (idx < IDXW'(NREG)) ? mem_q[idx[AW-1:0]] : 8'hFF;
endmodule

// File: rtl/smb_idx_target.sv
module smb_idx_target
  import smb_idx_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR = 7'h6C,
  parameter int         SEL_W     = 2,
  parameter int         NREG      = 8,
  parameter int         FILT      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] addr_sel,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe
);
  localparam int IDXW = 8;

  logic       rst_s_n;
  logic [1:0] raw_w, filt_w;
  logic       scl_f, sda_f;
  logic       scl_rise, scl_fall, start_ev, stop_ev;
  logic [6:0] my_addr;

  smb_st_e         state_q, state_d, after_q, after_d;
  logic [7:0]      shr_q, shr_d, tx_q, tx_d, left_q, left_d, cnt_q, cnt_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [2:0]      bitc_q, bitc_d;
  logic            got_q, got_d, oe_q, oe_d;
  logic            wr_en;
  logic [7:0]      rd_data;
  logic            mid_byte;

  smb_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_s_n));

  assign raw_w = {sda_i, scl_i};
  for (genvar g = 0; g < 2; g++) begin : g_line
    smb_line_filter #(.FILT(FILT)) u_filt (
      .clk(clk), .rst_n(rst_s_n), .line_i(raw_w[g]), .line_o(filt_w[g])
    );
  end
  assign scl_f = filt_w[0];
  assign sda_f = filt_w[1];

  smb_bus_events u_evt (
    .clk(clk), .rst_n(rst_s_n), .scl(scl_f), .sda(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  smb_regfile #(.NREG(NREG), .IDXW(IDXW)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .idx(idx_q),
    .wr_data(shr_q), .rd_data(rd_data)
  );

  assign my_addr  = {BASE_ADDR[6:SEL_W], addr_sel};
  assign mid_byte = (bitc_q != 3'd0) || (state_q == ST_ACK) || (state_q == ST_TACK);

  always_comb begin
    state_d = state_q;
    after_d = after_q;
    shr_d   = shr_q;
    tx_d    = tx_q;
    left_d  = left_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    bitc_d  = bitc_q;
    got_d   = got_q;
    oe_d    = oe_q;
    wr_en   = 1'b0;
    if (stop_ev) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      bitc_d  = 3'd0;
      got_d   = 1'b0;
    end else if (start_ev) begin
      state_d = mid_byte ? ST_IDLE : ST_ADDR;
      oe_d    = 1'b0;
      bitc_d  = 3'd0;
      got_d   = 1'b0;
    end else if (scl_rise) begin
      shr_d = {shr_q[6:0], sda_f};
      got_d = 1'b1;
    end else if (scl_fall) begin
      got_d = 1'b0;
      case (state_q)
        ST_ADDR, ST_IDX, ST_CNT, ST_WDAT: begin
          if (got_q) begin
            if (bitc_q != 3'd7) begin
              bitc_d = bitc_q + 3'd1;
            end else begin
              bitc_d  = 3'd0;
              state_d = ST_ACK;
              after_d = ST_IDLE;
              case (state_q)
                ST_ADDR: begin
                  if (shr_q[7:1] == my_addr) begin
                    oe_d = 1'b1;
                    if (shr_q[0]) begin
                      after_d = ST_TX;
                      tx_d    = cnt_q;
                    end else begin
                      after_d = ST_IDX;
                    end
                  end
                end
                ST_IDX: begin
                  oe_d    = 1'b1;
                  idx_d   = shr_q;
                  after_d = ST_CNT;
                end
                ST_CNT: begin
                  oe_d    = 1'b1;
                  cnt_d   = shr_q;
                  left_d  = shr_q;
                  after_d = ST_WDAT;
                end
                default: begin
                  if (left_q != 8'd0) begin
                    oe_d    = 1'b1;
                    wr_en   = 1'b1;
                    idx_d   = idx_q + 8'd1;
                    left_d  = left_q - 8'd1;
                    after_d = ST_WDAT;
                  end
                end
              endcase
            end
          end
        end
        ST_ACK: begin
          state_d = after_q;
          oe_d    = (after_q == ST_TX) ? ~tx_q[7] : 1'b0;
        end
        ST_TX: begin
          if (bitc_q == 3'd7) begin
            bitc_d  = 3'd0;
            oe_d    = 1'b0;
            state_d = ST_TACK;
          end else begin
            bitc_d = bitc_q + 3'd1;
            tx_d   = {tx_q[6:0], 1'b0};
            oe_d   = ~tx_q[6];
          end
        end
        ST_TACK: begin
          if (!shr_q[0]) begin
            tx_d    = rd_data;
            idx_d   = idx_q + 8'd1;
            oe_d    = ~rd_data[7];
            state_d = ST_TX;
          end else begin
            state_d = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      after_q <= ST_IDLE;
      shr_q   <= 8'h00;
      tx_q    <= 8'h00;
      left_q  <= 8'h00;
      cnt_q   <= 8'(NREG);
      idx_q   <= '0;
      bitc_q  <= 3'd0;
      got_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      after_q <= after_d;
      shr_q   <= shr_d;
      tx_q    <= tx_d;
      left_q  <= left_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      bitc_q  <= bitc_d;
      got_q   <= got_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/smb_idx_target_chk.sv
module smb_idx_target_chk
  import smb_idx_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    scl_f,
  input logic    sda_oe,
  input logic    start_ev,
  input logic    stop_ev,
  input smb_st_e state_q
);
  // R10
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe && (state_q == ST_IDLE));

  // R9
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe && ((state_q == ST_ADDR) || (state_q == ST_IDLE)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe);

  // R7
  drive_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> ((state_q == ST_ACK) || (state_q == ST_TX)));
endmodule

bind smb_idx_target smb_idx_target_chk u_chk (
  .clk(clk), .rst_n(rst_s_n), .scl_f(scl_f), .sda_oe(sda_oe),
  .start_ev(start_ev), .stop_ev(stop_ev), .state_q(state_q)
);

// File: tb/smb_idx_target_tb.sv
`timescale 1ns/1ps
module smb_idx_target_tb;
  localparam int         NREG = 8;
  localparam logic [6:0] BASE = 7'h6C;
  localparam int         Q    = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] addr_sel;
  logic       host_scl, host_sda;
  logic       sda_oe;
  logic       sda_bus;
  logic [7:0] m_reg [NREG];
  int         m_cnt;
  int         vecs = 0;
  int         fails = 0;

  always #2.5 clk = ~clk;

  assign sda_bus = host_sda & ~sda_oe;

  smb_idx_target u_dut (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
    .scl_i(host_scl), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
  endtask

  function automatic logic [7:0] pat(int i, int s);
    return 8'((i * 29 + s * 71) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] addr_byte(logic [1:0] sel, bit rd);
    return {BASE[6:2], sel, rd};
  endfunction

  task automatic bus_start();
    host_sda = 1'b1; tick(Q);
    host_scl = 1'b1; tick(Q);
    host_sda = 1'b0; tick(Q);
    host_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; tick(Q);
    host_scl = 1'b1; tick(Q);
    host_sda = 1'b1; tick(Q);
  endtask

  task automatic put_bit(bit b);
    host_sda = b;    tick(Q);
    host_scl = 1'b1; tick(Q);
    host_scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output bit b);
    host_sda = 1'b1; tick(Q);
    host_scl = 1'b1; tick(Q / 2);
    b = sda_bus;     tick(Q / 2);
    host_scl = 1'b0; tick(Q);
  endtask

  task automatic put_byte(logic [7:0] v, output int ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = b ? 0 : 1;
  endtask

  task automatic get_byte(bit ack_it, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(!ack_it);
  endtask

  task automatic do_write(int n, int x, int nb, int seed);
    int ack;
    logic [7:0] d;
    bus_start();
    put_byte(addr_byte(addr_sel, 1'b0), ack); chk("R1 write address ack", ack, 1);
    put_byte(8'(n), ack);                     chk("R2 index ack", ack, 1);
    put_byte(8'(x), ack);                     chk("R3 count ack", ack, 1);
    m_cnt = x;
    for (int i = 0; i < nb; i++) begin
      d = pat(n + i, seed);
      put_byte(d, ack);
      chk("R5 R6 data ack", ack, (i < x) ? 1 : 0);
      if (i < x && n + i < NREG) m_reg[n + i] = d;
    end
    bus_stop();
  endtask

  task automatic do_read(int n, int nb);
    int ack;
    logic [7:0] v;
    bus_start();
    put_byte(addr_byte(addr_sel, 1'b0), ack); chk("R1 write address ack", ack, 1);
    put_byte(8'(n), ack);                     chk("R2 index ack", ack, 1);
    bus_start();
    put_byte(addr_byte(addr_sel, 1'b1), ack); chk("R7 read address ack", ack, 1);
    get_byte(1'b1, v);                        chk("R3 R7 count byte", v, m_cnt);
    for (int i = 0; i < nb; i++) begin
      get_byte(i < nb - 1, v);
      if (n + i < NREG) chk("R4 R7 data", v, m_reg[n + i]);
      else              chk("R8 past end", v, 8'hFF);
    end
    chk("R8 released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int ack;
    logic [7:0] dv;
    rst_n = 1'b0; host_scl = 1'b1; host_sda = 1'b1; addr_sel = 2'd0;
    for (int i = 0; i < NREG; i++) m_reg[i] = 8'h00;
    m_cnt = NREG;
    tick(5);
    rst_n = 1'b1;
    tick(10);
    chk("R10 released out of reset", sda_oe, 0);

    // R1: every strap value against every low-address value
    for (int s = 0; s < 4; s++) begin
      addr_sel = 2'(s);
      for (int a = 0; a < 4; a++) begin
        bus_start();
        put_byte(addr_byte(2'(a), 1'b0), ack);
        chk("R1 address match", ack, (a == s) ? 1 : 0);
        if (ack == 0) begin
          put_byte(addr_byte(2'(s), 1'b0), ack);
          chk("R1 ignored until start", ack, 0);
        end
        bus_stop();
      end
    end
    addr_sel = 2'd1;

    // R3 R4 R8: reset contents
    do_read(0, NREG + 2);

    // R4: fill every register, then read from each start index
    do_write(0, NREG, NREG, 3);
    for (int n = 0; n < NREG; n++) do_read(n, NREG + 1 - n);

    // R5: more bytes than the count
    do_write(2, 3, 5, 7);
    do_read(0, NREG);

    // R6: run past the last register
    do_write(NREG - 2, 4, 4, 11);
    do_read(NREG - 3, 5);

    // R5: zero count
    do_write(6, 0, 1, 13);
    do_read(5, 4);

    // R9: stop in the middle of a data byte
    bus_start();
    put_byte(addr_byte(addr_sel, 1'b0), ack); chk("R9 setup", ack, 1);
    put_byte(8'd1, ack);                      chk("R9 setup", ack, 1);
    put_byte(8'd1, ack);                      chk("R9 setup", ack, 1);
    m_cnt = 1;
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    do_read(0, 3);

    // R9: start in the middle of a data byte
    bus_start();
    put_byte(addr_byte(addr_sel, 1'b0), ack); chk("R9 setup", ack, 1);
    put_byte(8'd3, ack);                      chk("R9 setup", ack, 1);
    put_byte(8'd2, ack);                      chk("R9 setup", ack, 1);
    m_cnt = 2;
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    put_byte(addr_byte(addr_sel, 1'b0), ack); chk("R9 ignored after mid-byte start", ack, 0);
    bus_stop();
    do_read(2, 3);

    // R11: short pulses on both lines during a data byte
    bus_start();
    put_byte(addr_byte(addr_sel, 1'b0), ack); chk("R11 setup", ack, 1);
    put_byte(8'd5, ack);                      chk("R11 setup", ack, 1);
    put_byte(8'd1, ack);                      chk("R11 setup", ack, 1);
    m_cnt = 1;
    dv = 8'hB6;
    for (int i = 7; i >= 0; i--) begin
      host_sda = dv[i]; tick(Q);
      host_scl = 1'b1;
      if (dv[i]) begin
        tick(4); host_sda = 1'b0; tick(2); host_sda = 1'b1; tick(Q - 6);
      end else begin
        tick(Q);
      end
      host_scl = 1'b0; tick(4);
      host_scl = 1'b1; tick(2);
      host_scl = 1'b0; tick(Q - 6);
    end
    begin
      bit b;
      get_bit(b);
      chk("R11 glitched byte ack", b ? 0 : 1, 1);
    end
    m_reg[5] = dv;
    bus_stop();
    do_read(4, 3);

    summary();
    $finish;
  end
endmodule